// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block collects event pulses from the transmit, receive and PHY-management sides of a network controller. It keeps them in a 32-bit main status register and a 16-bit PHY-management status register. Each status register has a mask register beside it, and a mask bit of 1 hides the matching status bit. The block drives one level-sensitive interrupt line from whatever is left unmasked. The PHY-management status does not drive the line directly. When any of its unmasked bits is set, it raises a summary bit (bit 23) in the effective main status. That summary is gated only by main mask bit 23.

Software reaches the registers through a simple 32-bit port with byte offsets. Reading either status register returns its value and then clears it. The main status clears every bit except the summary position. The PHY-management status clears to zero. Two extra offsets mirror the main status and main mask registers. A small reset register holds a transmit-reset request and a receive-reset request. Each request stays up until the matching completion pulse arrives.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the main mask reads 0xff7fffff, the PHY-management mask reads 0x0000ffff, both status registers and the reset register read 0, and the interrupt output is low.
- R2: A one-cycle pulse on rxDonePulse, noRxDescPulse, txDonePulse or txDrainPulse sets main status bit 16, 17, 24 or 25 respectively. A pulse on bit n of mifEventPulse sets bit n of the PHY-management status (offset 0x118).
- R3: The interrupt is high exactly when some main status bit other than bit 23 is set while its main mask bit (offset 0x104) is 0, or when the summary of R4 is active. A mask bit of 1 disables its status bit.
- R4: The summary is active when some PHY-management status bit is set while its mask bit (offset 0x114, low 16 bits) is 0, and main mask bit 23 is 0. A main status bit 23 written by software has no effect on the interrupt.
- R5: Reading the main status (offset 0x100) returns the stored bits, with bit 23 also showing whether any unmasked PHY-management bit is set. The read then clears every stored bit except bit 23.
- R6: Reading the PHY-management status (offset 0x118) returns its value and then clears it to zero.
- R7: Offset 0x108 behaves as the main status and offset 0x10c behaves as the main mask, for both reads and writes, including the clear-on-read of R5.
- R8: Writing 1 to bit 0 or bit 1 of the reset register (offset 0x000) raises txResetActive or rxResetActive respectively. Each stays high and reads back as 1 until its completion pulse (txResetDone or rxResetDone) arrives, and then it drops.
- R9: When an event pulse and a clear-on-read of the same status register fall in the same cycle, the read returns the old value and the new event bit remains set afterwards.
- R10: The interrupt output is registered. It changes one cycle after the status or mask register change that causes it.
- R11: Read data appears on regRdData one cycle after the read strobe and holds until the next read. Reading an unmapped offset returns 0, and writing an unmapped offset changes no register.
- R12: A write to a status or mask register replaces its contents. The PHY-management registers keep only the low 16 bits of the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Byte offset of the register access |
| regWrEn | input | 1 | Write strobe, one cycle |
| regRdEn | input | 1 | Read strobe, one cycle (ignored when regWrEn is high) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after regRdEn |
| rxDonePulse | input | 1 | Receive-complete event |
| noRxDescPulse | input | 1 | No-receive-descriptor event |
| txDonePulse | input | 1 | Transmit-complete event |
| txDrainPulse | input | 1 | Transmit-all-drained event |
| mifEventPulse | input | 16 | PHY-management event bits |
| txResetDone | input | 1 | Transmit reset completed |
| rxResetDone | input | 1 | Receive reset completed |
| txResetActive | output | 1 | Transmit reset request pending |
| rxResetActive | output | 1 | Receive reset request pending |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
The hardest case is an event pulse that lands in the same cycle as a clear-on-read of the status register it sets. The stimulus reaches it by raising the read strobe and the pulse at the same falling edge. It then confirms two results: the returned word lacks the new bit, and a second read shows the bit survived. The two-level summary is the second hard case. The bench unmasks one PHY-management bit and fires it, then toggles main mask bit 23. This shows that the interrupt follows only the summary gating and ignores a software-written bit 23.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int unsigned OFF_RESET      = 32'h000;
  localparam int unsigned OFF_STAT       = 32'h100;
  localparam int unsigned OFF_MASK       = 32'h104;
  localparam int unsigned OFF_STAT_ALIAS = 32'h108;
  localparam int unsigned OFF_MASK_ALIAS = 32'h10c;
  localparam int unsigned OFF_MIF_MASK   = 32'h114;
  localparam int unsigned OFF_MIF_STAT   = 32'h118;

  localparam int unsigned BIT_RX_DONE  = 16;
  localparam int unsigned BIT_NO_RXD   = 17;
  localparam int unsigned BIT_SUMMARY  = 23;
  localparam int unsigned BIT_TX_DONE  = 24;
  localparam int unsigned BIT_TX_DRAIN = 25;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RESET,
    SEL_STAT,
    SEL_MASK,
    SEL_MIF_STAT,
    SEL_MIF_MASK
  } regSel_e;

  typedef struct packed {
    logic    wrReset;
    logic    wrStat;
    logic    wrMask;
    logic    wrMifStat;
    logic    wrMifMask;
    logic    rdStat;
    logic    rdMifStat;
    logic    rdEn;
    regSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output strobe_t           stb
);

  regSel_e sel;
  logic    doWr;
  logic    doRd;

  // Aliased offsets decode onto the same target as their primary offsets.
  always_comb begin
    sel = SEL_NONE;
    case (regAddr)
      ADDR_W'(OFF_RESET):      sel = SEL_RESET;
      ADDR_W'(OFF_STAT):       sel = SEL_STAT;
      ADDR_W'(OFF_STAT_ALIAS): sel = SEL_STAT;
      ADDR_W'(OFF_MASK):       sel = SEL_MASK;
      ADDR_W'(OFF_MASK_ALIAS): sel = SEL_MASK;
      ADDR_W'(OFF_MIF_STAT):   sel = SEL_MIF_STAT;
      ADDR_W'(OFF_MIF_MASK):   sel = SEL_MIF_MASK;
      default:                 sel = SEL_NONE;
    endcase
  end

  assign doWr = regWrEn;
  assign doRd = regRdEn && !regWrEn;

  always_comb begin
    stb.wrReset   = doWr && (sel == SEL_RESET);
    stb.wrStat    = doWr && (sel == SEL_STAT);
    stb.wrMask    = doWr && (sel == SEL_MASK);
    stb.wrMifStat = doWr && (sel == SEL_MIF_STAT);
    stb.wrMifMask = doWr && (sel == SEL_MIF_MASK);
    stb.rdStat    = doRd && (sel == SEL_STAT);
    stb.rdMifStat = doRd && (sel == SEL_MIF_STAT);
    stb.rdEn      = doRd;
    stb.rdSel     = doRd ? sel : SEL_NONE;
  end

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned MIF_W         = 16,
  parameter int unsigned RST_CH        = 2,
  parameter logic [31:0] MAIN_MASK_RST = 32'hff7f_ffff,
  parameter logic [15:0] MIF_MASK_RST  = 16'hffff
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              evRxDone,
  input  logic              evNoRxDesc,
  input  logic              evTxDone,
  input  logic              evTxDrain,
  input  logic [MIF_W-1:0]  evMif,
  input  logic [RST_CH-1:0] rstDone,
  output logic [DATA_W-1:0] rdData,
  output logic [RST_CH-1:0] rstActive,
  output logic              irq
);

  localparam logic [DATA_W-1:0] SUM_ONE = DATA_W'(1) << BIT_SUMMARY;

  logic [DATA_W-1:0] statQ, maskQ, statSet, statNext;
  logic [MIF_W-1:0]  mifStatQ, mifMaskQ, mifNext;
  logic [DATA_W-1:0] effective;
  logic              mifAny, summary, irqNext;

  // Event pulses mapped onto their fixed status positions.
  always_comb begin
    statSet               = '0;
    statSet[BIT_RX_DONE]  = evRxDone;
    statSet[BIT_NO_RXD]   = evNoRxDesc;
    statSet[BIT_TX_DONE]  = evTxDone;
    statSet[BIT_TX_DRAIN] = evTxDrain;
  end

  // Main status: write replaces, read clears all but the summary slot, set wins.
  always_comb begin
    if (stb.wrStat)      statNext = wrData | statSet;
    else if (stb.rdStat) statNext = (statQ & SUM_ONE) | statSet;
    else                 statNext = statQ | statSet;
  end

  always_comb begin
    if (stb.wrMifStat)      mifNext = wrData[MIF_W-1:0] | evMif;
    else if (stb.rdMifStat) mifNext = evMif;
    else                    mifNext = mifStatQ | evMif;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ    <= '0;
      mifStatQ <= '0;
      maskQ    <= MAIN_MASK_RST[DATA_W-1:0];
      mifMaskQ <= MIF_MASK_RST[MIF_W-1:0];
    end else begin
      statQ    <= statNext;
      mifStatQ <= mifNext;
      if (stb.wrMask)    maskQ    <= wrData;
      if (stb.wrMifMask) mifMaskQ <= wrData[MIF_W-1:0];
    end
  end

  // Reset-request channels, one per sub-block.
  for (genvar g = 0; g < RST_CH; g++) begin : g_rstCh
    logic chanQ;
    always_ff @(posedge clk) begin
      if (!rstN)                          chanQ <= 1'b0;
      else if (stb.wrReset && wrData[g])  chanQ <= 1'b1;
      else if (rstDone[g])                chanQ <= 1'b0;
    end
    assign rstActive[g] = chanQ;
  end

  // Two-level aggregation.
  assign mifAny    = |(mifStatQ & ~mifMaskQ);
  assign summary   = mifAny && !maskQ[BIT_SUMMARY];
  assign effective = statQ & ~maskQ & ~SUM_ONE;
  assign irqNext   = (|effective) || summary;

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= irqNext;
  end

  // Read data, captured with the pre-clear values.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdEn) begin
      case (stb.rdSel)
        SEL_RESET:    rdData <= {{(DATA_W-RST_CH){1'b0}}, rstActive};
        SEL_STAT:     rdData <= statQ | (mifAny ? SUM_ONE : '0);
        SEL_MASK:     rdData <= maskQ;
        SEL_MIF_STAT: rdData <= {{(DATA_W-MIF_W){1'b0}}, mifStatQ};
        SEL_MIF_MASK: rdData <= {{(DATA_W-MIF_W){1'b0}}, mifMaskQ};
        default:      rdData <= '0;
      endcase
    end
  end

  // R5: a read with no concurrent event leaves only the summary slot.
  a_r5_rtc_keeps_summary: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStat && statSet == '0) |=> ((statQ & ~SUM_ONE) == '0));

  // R6: reading the PHY-management status empties it.
  a_r6_mif_rtc: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdMifStat && evMif == '0) |=> (mifStatQ == '0));

  // R9: an event beats a same-cycle clear.
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (evTxDone && stb.rdStat) |=> statQ[BIT_TX_DONE]);

  // R4: an unmasked PHY-management bit with bit 23 unmasked raises the line.
  a_r4_summary_irq: assert property (@(posedge clk) disable iff (!rstN)
    (mifAny && !maskQ[BIT_SUMMARY]) |=> irq);

  // R8: completion drops a request unless it is being re-requested.
  a_r8_tx_selfclear: assert property (@(posedge clk) disable iff (!rstN)
    (rstDone[0] && !(stb.wrReset && wrData[0])) |=> !rstActive[0]);

  // R2: receive-complete pulse lands in bit 16.
  a_r2_rx_sets: assert property (@(posedge clk) disable iff (!rstN)
    evRxDone |=> statQ[BIT_RX_DONE]);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MIF_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              rxDonePulse,
  input  logic              noRxDescPulse,
  input  logic              txDonePulse,
  input  logic              txDrainPulse,
  input  logic [MIF_W-1:0]  mifEventPulse,
  input  logic              txResetDone,
  input  logic              rxResetDone,
  output logic              txResetActive,
  output logic              rxResetActive,
  output logic              irq
);

  localparam int unsigned RST_CH = 2;

  strobe_t           stb;
  logic [RST_CH-1:0] rstActive;

  irq_agg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .stb     (stb)
  );

  irq_agg_datapath #(
    .DATA_W (DATA_W),
    .MIF_W  (MIF_W),
    .RST_CH (RST_CH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (regWrData),
    .evRxDone   (rxDonePulse),
    .evNoRxDesc (noRxDescPulse),
    .evTxDone   (txDonePulse),
    .evTxDrain  (txDrainPulse),
    .evMif      (mifEventPulse),
    .rstDone    ({rxResetDone, txResetDone}),
    .rdData     (regRdData),
    .rstActive  (rstActive),
    .irq        (irq)
  );

  assign txResetActive = rstActive[0];
  assign rxResetActive = rstActive[1];

endmodule

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        rxDonePulse = 1'b0, noRxDescPulse = 1'b0;
  logic        txDonePulse = 1'b0, txDrainPulse = 1'b0;
  logic [15:0] mifEventPulse = '0;
  logic        txResetDone = 1'b0, rxResetDone = 1'b0;
  logic        txResetActive, rxResetActive, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .rxDonePulse(rxDonePulse), .noRxDescPulse(noRxDescPulse),
    .txDonePulse(txDonePulse), .txDrainPulse(txDrainPulse),
    .mifEventPulse(mifEventPulse), .txResetDone(txResetDone),
    .rxResetDone(rxResetDone), .txResetActive(txResetActive),
    .rxResetActive(rxResetActive), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic pulse(input int which, input logic [15:0] mifBits);
    @(negedge clk);
    case (which)
      0: rxDonePulse = 1'b1;
      1: noRxDescPulse = 1'b1;
      2: txDonePulse = 1'b1;
      3: txDrainPulse = 1'b1;
      default: mifEventPulse = mifBits;
    endcase
    @(negedge clk);
    rxDonePulse = 1'b0; noRxDescPulse = 1'b0; txDonePulse = 1'b0;
    txDrainPulse = 1'b0; mifEventPulse = '0;
  endtask

  task automatic testResetState();
    logic [31:0] d;
    check("R1 irq", {31'd0, irq}, 32'd0);
    regRead(12'h104, d); check("R1 main mask", d, 32'hff7fffff);
    regRead(12'h114, d); check("R1 mif mask", d, 32'h0000ffff);
    regRead(12'h100, d); check("R1 status", d, 32'h0);
    regRead(12'h118, d); check("R1 mif status", d, 32'h0);
    regRead(12'h000, d); check("R1 reset reg", d, 32'h0);
  endtask

  task automatic testEvents();
    logic [31:0] d;
    pulse(0, '0); pulse(1, '0); pulse(2, '0); pulse(3, '0);
    pulse(4, 16'h0020);
    @(negedge clk);
    check("R3 all masked irq low", {31'd0, irq}, 32'd0);
    regRead(12'h100, d); check("R2 status bits", d, 32'h03030000);
    regRead(12'h118, d); check("R2 mif bit", d, 32'h00000020);
    regRead(12'h100, d); check("R5 cleared", d, 32'h0);
    regRead(12'h118, d); check("R6 mif cleared", d, 32'h0);
  endtask

  task automatic testMaskAndLatency();
    logic [31:0] d;
    pulse(2, '0);
    @(negedge clk);
    check("R3 masked tx", {31'd0, irq}, 32'd0);
    regWrite(12'h104, 32'hfeffffff);
    check("R10 irq one cycle late", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R3 unmasked tx irq", {31'd0, irq}, 32'd1);
    regRead(12'h100, d);
    check("R5 read value", d, 32'h01000000);
    check("R10 irq still high", {31'd0, irq}, 32'd1);
    @(negedge clk);
    check("R5 irq low after clear", {31'd0, irq}, 32'd0);
    regWrite(12'h104, 32'hff7fffff);
  endtask

  task automatic testSummary();
    logic [31:0] d;
    regWrite(12'h100, 32'h00800000);
    @(negedge clk); @(negedge clk);
    check("R4 sw bit23 no irq", {31'd0, irq}, 32'd0);
    regRead(12'h100, d); check("R5 bit23 survives", d, 32'h00800000);
    regRead(12'h100, d); check("R5 bit23 still", d, 32'h00800000);
    regWrite(12'h100, 32'h0);
    regWrite(12'h114, 32'h0000fffe);
    pulse(4, 16'h0001);
    @(negedge clk);
    check("R4 summary irq", {31'd0, irq}, 32'd1);
    regRead(12'h100, d); check("R5 summary visible", d, 32'h00800000);
    regWrite(12'h104, 32'hffffffff);
    @(negedge clk);
    check("R4 gated by bit23", {31'd0, irq}, 32'd0);
    regWrite(12'h104, 32'hff7fffff);
    @(negedge clk);
    check("R4 ungated again", {31'd0, irq}, 32'd1);
    regRead(12'h118, d); check("R6 mif read", d, 32'h00000001);
    regRead(12'h118, d); check("R6 mif empty", d, 32'h0);
    @(negedge clk);
    check("R6 irq dropped", {31'd0, irq}, 32'd0);
  endtask

  task automatic testAlias();
    logic [31:0] d;
    regWrite(12'h10c, 32'hfffeffff);
    regRead(12'h104, d); check("R7 mask alias write", d, 32'hfffeffff);
    regRead(12'h10c, d); check("R7 mask alias read", d, 32'hfffeffff);
    pulse(0, '0);
    @(negedge clk);
    check("R7 irq rx", {31'd0, irq}, 32'd1);
    regRead(12'h108, d); check("R7 status alias read", d, 32'h00010000);
    regRead(12'h100, d); check("R7 alias cleared", d, 32'h0);
    regWrite(12'h108, 32'h00020000);
    regRead(12'h100, d); check("R7 status alias write", d, 32'h00020000);
    regWrite(12'h104, 32'hff7fffff);
  endtask

  task automatic testSetWins();
    logic [31:0] d;
    @(negedge clk);
    regAddr = 12'h100; regRdEn = 1'b1; txDrainPulse = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0; txDrainPulse = 1'b0;
    check("R9 old value", regRdData, 32'h0);
    regRead(12'h100, d); check("R9 event kept", d, 32'h02000000);
    @(negedge clk);
    regAddr = 12'h118; regRdEn = 1'b1; mifEventPulse = 16'h8000;
    @(negedge clk);
    regRdEn = 1'b0; mifEventPulse = '0;
    check("R9 mif old value", regRdData, 32'h0);
    regRead(12'h118, d); check("R9 mif event kept", d, 32'h00008000);
  endtask

  task automatic testResetReg();
    logic [31:0] d;
    regWrite(12'h000, 32'h3);
    check("R8 tx active", {31'd0, txResetActive}, 32'd1);
    check("R8 rx active", {31'd0, rxResetActive}, 32'd1);
    regRead(12'h000, d); check("R8 both pending", d, 32'h3);
    @(negedge clk); txResetDone = 1'b1;
    @(negedge clk); txResetDone = 1'b0;
    regRead(12'h000, d); check("R8 tx cleared", d, 32'h2);
    @(negedge clk); rxResetDone = 1'b1;
    @(negedge clk); rxResetDone = 1'b0;
    check("R8 rx inactive", {31'd0, rxResetActive}, 32'd0);
    regRead(12'h000, d); check("R8 none pending", d, 32'h0);
  endtask

  task automatic testUnmappedAndWidth();
    logic [31:0] d;
    regWrite(12'h1f0, 32'hffffffff);
    regRead(12'h1f0, d); check("R11 unmapped read", d, 32'h0);
    regRead(12'h104, d); check("R11 mask untouched", d, 32'hff7fffff);
    regRead(12'h100, d); check("R11 status untouched", d, 32'h0);
    regWrite(12'h114, 32'h1234abcd);
    regRead(12'h114, d); check("R12 mif mask low half", d, 32'h0000abcd);
    regWrite(12'h118, 32'h5555aaaa);
    regRead(12'h118, d); check("R12 mif status write", d, 32'h0000aaaa);
    regWrite(12'h114, 32'h0000ffff);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testEvents();
    testMaskAndLatency();
    testSummary();
    testAlias();
    testSetWins();
    testResetReg();
    testUnmappedAndWidth();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule